// File: doc/BRIEF.md
# Pipeline Flow Controller with Stall and Kill

This block is the control half of an n-stage pipeline. It keeps one registered valid bit per stage and, each cycle, tells every stage's register barrier what to do: load an empty operation, load what the stage below produced, or hold what it already has. The datapath, the per-stage computations and whatever raises stall or kill requests are outside the block. The block only turns those requests into per-stage commands, and it tracks where valid operations sit.

With no requests active, the valid vector moves up by one stage per cycle. Stage 0 takes a token when a new operation is offered. A stall request at stage f freezes stages 0 to f and puts a bubble into stage f+1, while the stages above keep draining. When several stalls are raised at once, the highest one decides the frozen prefix. A kill request turns one slot into a bubble without halting anything else. A synchronous reset empties the whole pipe.

Command encoding per stage, two bits: 00 empty, 01 load from upstream (or from the new operation at stage 0), 10 hold. Stage j uses bits [2j+1:2j] of `stageCmd`.

Top module: `pflow_ctl`

## Requirements
- R1: While `rst` is high, every stage command is 00. After the next clock edge, every bit of `stageValid` is 0.
- R2: With no stall and no kill request, every stage j>0 gets command 01, and after the edge stage j holds the valid bit that stage j-1 had.
- R3: Let f be the highest stage with an active stall request. Every stage 0..f gets command 10 and keeps its valid bit across the edge.
- R4: While a stall is active at highest stage f with f+1 < n, stage f+1 gets command 00 and is empty after the edge.
- R5: While a stall is active at highest stage f, every stage above f+1 gets command 01 and takes the valid bit of the stage below it.
- R6: A stall request below the highest active one changes nothing; the outputs are those for the highest stall alone.
- R7: Every operation accepted into stage 0 leaves the last stage exactly once and in order of entry, unless it was killed or wiped by reset. Releasing a stall loses and duplicates nothing.
- R8: A kill request at a stage that is not frozen gives that stage command 00 and leaves it empty after the edge. Every other stage behaves as it would without the kill.
- R9: A kill request at the same stage as the highest active stall wins for that stage (command 00, empty after the edge). The stages below it still get command 10.
- R10: A kill request at a stage below the highest active stall is ignored: that stage still gets command 10 and keeps its valid bit.
- R11: The code 11 never appears on any stage command.
- R12: With no stall active and no kill at stage 0, stage 0 gets 01 when `opValid` is high and 00 when it is low, and its valid bit follows `opValid` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset that empties every stage |
| opValid | input | 1 | A new operation is offered to stage 0 this cycle |
| stallReq | input | Stages | Stall request per stage, bit j for stage j |
| killReq | input | Stages | Kill request per stage, bit j for stage j |
| stageCmd | output | 2*Stages | Per-stage register command, 2 bits per stage |
| stageValid | output | Stages | Registered valid bit per stage |

## Verification
The hardest cases to reach are the ones that depend on what the pipe already holds when a request arrives. Examples are a kill landing on the frozen top stage while a lower stall is also raised, or a stall released over a partly filled prefix. The bench reaches them with a sweep. Before each step it empties the pipe and shifts in every possible occupancy pattern. It then applies every combination of stall requests, kill requests and `opValid` for one cycle, followed by two free cycles. A longer pseudo-random run then tags every accepted operation with a sequence number and checks the order in which operations leave the last stage.

// File: rtl/pflow_pkg.sv
package pflow_pkg;

  // Per-stage register-barrier command
  typedef enum logic [1:0] {
    CMD_EMPTY = 2'b00,
    CMD_LOAD  = 2'b01,
    CMD_HOLD  = 2'b10
  } pf_cmd_e;

  // Width of a stage index carried between control and datapath
  localparam int IDX_W = 8;

  // Strobes from the stall arbiter to the valid path
  typedef struct packed {
    logic             anyStall;
    logic [IDX_W-1:0] topIdx;
  } pf_stall_s;

endpackage

// File: rtl/pflow_stall_arb.sv
module pflow_stall_arb
  import pflow_pkg::*;
#(
  parameter int Stages = 4
) (
  input  logic [Stages-1:0] stallReq,
  output pf_stall_s         stallSt
);

  // Highest active request wins; the scan runs upward so later hits overwrite
  always_comb begin
    stallSt = '0;
    for (int j = 0; j < Stages; j++) begin
      if (stallReq[j]) begin
        stallSt.anyStall = 1'b1;
        stallSt.topIdx   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/pflow_valid_path.sv
module pflow_valid_path
  import pflow_pkg::*;
#(
  parameter int Stages = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  opValid,
  input  logic [Stages-1:0]     killReq,
  input  pf_stall_s             stallSt,
  output logic [2*Stages-1:0]   stageCmd,
  output logic [Stages-1:0]     stageValid
);

  localparam int CmdW = 2 * Stages;

  logic [Stages-1:0] validQ;
  logic [Stages-1:0] validD;
  logic [CmdW-1:0]   cmdVec;

  always_comb begin
    int top;
    pf_cmd_e c;
    top    = int'(stallSt.topIdx);
    cmdVec = '0;
    validD = '0;
    for (int j = 0; j < Stages; j++) begin
      if (rst)                                  c = CMD_EMPTY;
      else if (stallSt.anyStall && j < top)     c = CMD_HOLD;   // frozen prefix, kill ignored
      else if (killReq[j])                      c = CMD_EMPTY;  // kill wins at or above top
      else if (stallSt.anyStall && j == top)    c = CMD_HOLD;
      else if (stallSt.anyStall && j == top+1)  c = CMD_EMPTY;  // bubble above the freeze
      else if (j == 0)                          c = opValid ? CMD_LOAD : CMD_EMPTY;
      else                                      c = CMD_LOAD;
      cmdVec[2*j +: 2] = c;
      case (c)
        CMD_HOLD: validD[j] = validQ[j];
        CMD_LOAD: validD[j] = (j == 0) ? 1'b1 : validQ[(j == 0) ? 0 : j-1];
        default:  validD[j] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    validQ <= validD;
  end

  assign stageCmd   = cmdVec;
  assign stageValid = validQ;

endmodule

// File: rtl/pflow_ctl.sv
module pflow_ctl
  import pflow_pkg::*;
#(
  parameter int Stages = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  opValid,
  input  logic [Stages-1:0]     stallReq,
  input  logic [Stages-1:0]     killReq,
  output logic [2*Stages-1:0]   stageCmd,
  output logic [Stages-1:0]     stageValid
);

  pf_stall_s stallSt;

  pflow_stall_arb #(.Stages(Stages)) u_arb (
    .stallReq (stallReq),
    .stallSt  (stallSt)
  );

  pflow_valid_path #(.Stages(Stages)) u_path (
    .clk        (clk),
    .rst        (rst),
    .opValid    (opValid),
    .killReq    (killReq),
    .stallSt    (stallSt),
    .stageCmd   (stageCmd),
    .stageValid (stageValid)
  );

endmodule

// File: rtl/pflow_ctl_checker.sv
module pflow_ctl_checker #(
  parameter int Stages = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                opValid,
  input logic [Stages-1:0]   stallReq,
  input logic [Stages-1:0]   killReq,
  input logic [2*Stages-1:0] stageCmd,
  input logic [Stages-1:0]   stageValid
);

  // R1: reset empties the pipe
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> stageValid == '0)
    else $error("R1 pipe not empty after reset");

  p_reset_cmd_r1: assert property (@(posedge clk) rst |-> stageCmd == '0)
    else $error("R1 command not empty during reset");

  // R2: free flow is a one-slot shift
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (stallReq == '0 && killReq == '0) |=>
      stageValid == {$past(stageValid[Stages-2:0]), $past(opValid)})
    else $error("R2 free-flow shift broken");

  for (genvar j = 0; j < Stages; j++) begin : g_stage
    // R3 (with R6, R10): frozen stages keep their valid bit
    p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
      ((|(stallReq >> (j+1))) || (stallReq[j] && !killReq[j])) |=> $stable(stageValid[j]))
      else $error("R3 frozen stage %0d changed", j);

    // R8 (and R9 at the top stall stage): a kill that is not overridden empties the slot
    p_kill_r8: assert property (@(posedge clk) disable iff (rst)
      (killReq[j] && ((stallReq >> (j+1)) == '0)) |=> !stageValid[j])
      else $error("R8 killed stage %0d still valid", j);

    p_legal_r11: assert property (@(posedge clk) disable iff (rst)
      stageCmd[2*j +: 2] != 2'b11)
      else $error("R11 illegal command at stage %0d", j);

    if (j > 0) begin : g_bub
      p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (stallReq[j-1] && ((stallReq >> j) == '0)) |-> stageCmd[2*j +: 2] == 2'b00)
        else $error("R4 no bubble at stage %0d", j);
    end
  end

endmodule

bind pflow_ctl pflow_ctl_checker #(.Stages(Stages)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opValid    (opValid),
  .stallReq   (stallReq),
  .killReq    (killReq),
  .stageCmd   (stageCmd),
  .stageValid (stageValid)
);

// File: tb/pflow_ctl_test.sv
`timescale 1ns/1ps
module pflow_ctl_test;

  localparam int N = 4;
  localparam int WATCHDOG = 195000;

  logic           clk = 1'b0;
  logic           rst;
  logic           opValid;
  logic [N-1:0]   stallReq;
  logic [N-1:0]   killReq;
  logic [2*N-1:0] stageCmd;
  logic [N-1:0]   stageValid;

  always #2 clk = ~clk;  // 250 MHz

  pflow_ctl #(.Stages(N)) uut (
    .clk(clk), .rst(rst), .opValid(opValid), .stallReq(stallReq),
    .killReq(killReq), .stageCmd(stageCmd), .stageValid(stageValid)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  logic [N-1:0] mValid;
  int           mTag [N];
  int           nextSeq = 1;
  int           lastExit = 0;
  bit           killed [int];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic noteExit(input int t);
    chk(t > lastExit, "R7", "exit order", t, lastExit + 1);
    for (int x = lastExit + 1; x < t; x++)
      chk(killed.exists(x), "R7", "operation lost", x, t);
    if (t > lastExit) lastExit = t;
  endtask

  task automatic step(input logic r, input logic o,
                      input logic [N-1:0] s, input logic [N-1:0] k);
    int    top;
    int    nst;
    int    eCmd [N];
    string eLab [N];
    int    nTag [N];
    logic [N-1:0] nValid;
    rst = r; opValid = o; stallReq = s; killReq = k;
    #1;
    top = -1; nst = 0;
    for (int j = 0; j < N; j++) if (s[j]) begin top = j; nst++; end
    for (int j = 0; j < N; j++) begin
      if (r) begin eCmd[j] = 0; eLab[j] = "R1"; end
      else if (top >= 0 && j < top) begin
        eCmd[j] = 2;
        eLab[j] = k[j] ? "R10" : (nst > 1 ? "R6" : "R3");
      end
      else if (top >= 0 && j == top) begin
        eCmd[j] = k[j] ? 0 : 2; eLab[j] = k[j] ? "R9" : "R3";
      end
      else if (top >= 0 && j == top + 1) begin eCmd[j] = 0; eLab[j] = "R4"; end
      else if (k[j]) begin eCmd[j] = 0; eLab[j] = "R8"; end
      else if (j == 0) begin eCmd[j] = o ? 1 : 0; eLab[j] = "R12"; end
      else begin eCmd[j] = 1; eLab[j] = (top >= 0) ? "R5" : "R2"; end
      chk(stageCmd[2*j +: 2] != 2'b11, "R11", "code 11 on command", int'(stageCmd[2*j +: 2]), eCmd[j]);
      chk(int'(stageCmd[2*j +: 2]) == eCmd[j], eLab[j], $sformatf("cmd stage %0d", j),
          int'(stageCmd[2*j +: 2]), eCmd[j]);
    end
    // next model state
    for (int j = 0; j < N; j++) begin
      case (eCmd[j])
        2: begin nTag[j] = mTag[j]; nValid[j] = mValid[j]; end
        1: begin
             if (j == 0) begin nTag[j] = nextSeq; nextSeq++; nValid[j] = 1'b1; end
             else begin nTag[j] = mTag[j-1]; nValid[j] = mValid[j-1]; end
           end
        default: begin nTag[j] = 0; nValid[j] = 1'b0; end
      endcase
    end
    // operations that disappear: exit from the last stage or killed
    for (int j = 0; j < N; j++) begin
      if (mTag[j] != 0) begin
        bit kept = 0;
        for (int i = 0; i < N; i++) if (nTag[i] == mTag[j]) kept = 1;
        if (!kept) begin
          if (!r && j == N-1 && !(top == N-1 && k[N-1])) noteExit(mTag[j]);
          else killed[mTag[j]] = 1'b1;
        end
      end
    end
    for (int j = 0; j < N; j++) mTag[j] = nTag[j];
    mValid = nValid;
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < N; j++)
      chk(stageValid[j] === mValid[j], eLab[j], $sformatf("valid stage %0d", j),
          int'(stageValid[j]), int'(mValid[j]));
  endtask

  task automatic fill(input logic [N-1:0] p);
    step(1'b1, 1'b0, '0, '0);
    for (int b = N - 1; b >= 0; b--) step(1'b0, p[b], '0, '0);
    chk(stageValid == p, "R2", "prefill pattern", int'(stageValid), int'(p));
  endtask

  task automatic finish;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish();
    end
  end

  initial begin
    rst = 1'b1; opValid = 1'b0; stallReq = '0; killReq = '0;
    mValid = '0;
    for (int j = 0; j < N; j++) mTag[j] = 0;
    @(negedge clk);
    // reset state
    step(1'b1, 1'b1, '1, '1);
    chk(stageValid == '0, "R1", "valid after reset", int'(stageValid), 0);

    // sweep: every occupancy x every stall/kill/opValid combination, then release
    for (int p = 0; p < (1 << N); p++) begin
      for (int s = 0; s < (1 << N); s++) begin
        for (int k = 0; k < (1 << N); k++) begin
          for (int o = 0; o < 2; o++) begin
            fill(N'(p));
            step(1'b0, o[0], N'(s), N'(k));
            step(1'b0, 1'b1, '0, '0);
            step(1'b0, 1'b0, '0, '0);
          end
        end
      end
    end

    // long pseudo-random run with sequence tracking
    step(1'b1, 1'b0, '0, '0);
    for (int n = 0; n < 15000; n++) begin
      logic [N-1:0] s;
      logic [N-1:0] k;
      for (int j = 0; j < N; j++) begin
        s[j] = ($urandom % 8) == 0;
        k[j] = ($urandom % 10) == 0;
      end
      step(($urandom % 500) == 0, ($urandom % 4) != 0, s, k);
    end

    // drain and confirm every issued operation is accounted for (R7)
    for (int d = 0; d < N + 1; d++) step(1'b0, 1'b0, '0, '0);
    chk(stageValid == '0, "R7", "pipe drained", int'(stageValid), 0);
    for (int x = lastExit + 1; x < nextSeq; x++)
      chk(killed.exists(x), "R7", "operation never left", x, nextSeq - 1);

    finish();
  end

endmodule